// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Pacing

This block is the transmit half of an asynchronous serial port. A CPU writes bytes through a one-cycle write strobe. The block holds them either in a single holding slot or, in buffered mode, in a first-in first-out queue. It sends each byte on a serial output line. Bit timing comes from an oversampling tick that an external rate generator supplies. Each serial bit spans a fixed number of these tick pulses.

A ready output tells a DMA engine or the CPU whether another byte can be written. Two empty flags report the state: one for the byte store, and one for the whole transmit path including the shift register. An optional pacing mode uses a clear-to-send input. While that input is inactive, no new character is started. A character that has already begun is always sent to the end. A flush input discards any bytes still waiting in the store.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset the line `txd` is high, `hold_empty`, `shift_empty` and `dma_tx_ready` are all 1, and the block is idle. While `shift_empty` is 1, `txd` stays high.
- R2: Every character is sent as 1 start bit (low), then the DATA_W data bits with the least significant bit first, then 1 stop bit (high). That makes DATA_W+2 bit times per character.
- R3: Every data bit and the stop bit each last exactly OVS pulses of `tick16`. A pulse is a 1-cycle high level. The start bit runs from the launch cycle up to its OVS-th pulse.
- R4: With `fifo_en` = 0, the store holds one byte. `dma_tx_ready` is 0 exactly while that byte is present, and a write while it is present is discarded.
- R5: With `fifo_en` = 1, the store holds FIFO_DEPTH bytes and sends them in write order. `dma_tx_ready` is 0 exactly while the store is full.
- R6: A write to a full store is discarded, and the bytes already held are sent unchanged.
- R7: `hold_empty` is 1 exactly when the store holds no byte. `shift_empty` is 1 exactly when the store is empty and no character is being sent.
- R8: When a character ends and another byte is waiting, and pacing allows it, the next start bit begins without any extra bit time of idle line.
- R9: With `fifo_en` = 1 and `auto_cts_en` = 1, a new start bit is launched only while `cts` = 1 (1 means the peer is ready). Waiting bytes stay in the store while `cts` = 0.
- R10: If `cts` drops to 0 in the middle of a character, that character still completes with correct data and stop bit.
- R11: With `fifo_en` = 0, `auto_cts_en` and `cts` have no effect, and characters are sent whatever `cts` is.
- R12: `flush` = 1 empties the store at the next clock edge. A write in the same cycle is discarded, and a character already being sent completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe from the CPU |
| wr_data | input | DATA_W | Byte to transmit |
| tick16 | input | 1 | Oversampling tick, one-cycle pulse |
| fifo_en | input | 1 | 1 = FIFO_DEPTH-byte queue, 0 = single holding slot |
| auto_cts_en | input | 1 | 1 = pace character starts with `cts` (effective only in queue mode) |
| flush | input | 1 | Discard all bytes in the store |
| cts | input | 1 | Peer clear-to-send, 1 = ready (synchronous to `clk`) |
| txd | output | 1 | Serial output, idles high |
| dma_tx_ready | output | 1 | 1 = a write will be accepted |
| hold_empty | output | 1 | Store empty |
| shift_empty | output | 1 | Store empty and serializer idle |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and OVS = 4, and pulses the tick every second clock. This makes a character 80 clocks long, so the tests can fill the queue to its full level, write into a full queue and drain it again well inside the run budget. The short queue means the full boundary is reached after only a few writes, while the serializer is still busy with the first byte. The bench measures the exact length of a run of high data bits and checks it against the bit-time rule.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [0:0] {
      SER_IDLE = 1'b0,
      SER_RUN  = 1'b1
   } ser_state_e;

   localparam int unsigned FRAME_EXTRA_BITS = 2;

endpackage

// File: rtl/uart_tx_store.sv
module uart_tx_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              single_mode,
   input  logic              push_req,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic              is_empty,
   output logic              can_accept
);

   localparam int unsigned PTR_W   = $clog2(DEPTH);
   localparam int unsigned CNT_W   = $clog2(DEPTH + 1);
   localparam bit          IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  count;
   logic              cap_hit, accept, take;

   generate
      if (IS_POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign is_empty   = (count == '0);
   assign cap_hit    = single_mode ? !is_empty : (count == FULL_CNT);
   assign can_accept = !cap_hit;
   assign accept     = push_req && !cap_hit && !flush;
   assign take       = pop && !is_empty && !flush;
   assign head_data  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (accept) wr_ptr <= wr_nxt;
         if (take)   rd_ptr <= rd_nxt;
         case ({accept, take})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic [DATA_W-1:0] start_data,
   output logic              busy,
   output logic              txd
);

   localparam int unsigned FRAME_BITS = DATA_W + FRAME_EXTRA_BITS;
   localparam int unsigned TCNT_W     = $clog2(OVS);
   localparam int unsigned BCNT_W     = $clog2(FRAME_BITS);
   localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(OVS - 1);
   localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(FRAME_BITS - 1);

   ser_state_e            state;
   logic [FRAME_BITS-1:0] shreg;
   logic [TCNT_W-1:0]     tcnt;
   logic [BCNT_W-1:0]     bcnt;

   assign busy = (state == SER_RUN);
   assign txd  = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SER_IDLE;
         shreg <= '1;
         tcnt  <= '0;
         bcnt  <= '0;
      end else if (state == SER_IDLE) begin
         if (start) begin
            state <= SER_RUN;
            shreg <= {1'b1, start_data, 1'b0};
            tcnt  <= '0;
            bcnt  <= '0;
         end
      end else if (tick) begin
         if (tcnt == TCNT_LAST) begin
            tcnt <= '0;
            if (bcnt == BCNT_LAST) begin
               state <= SER_IDLE;
            end else begin
               bcnt  <= bcnt + 1'b1;
               shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
            end
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/uart_tx_launch.sv
module uart_tx_launch (
   input  logic fifo_en,
   input  logic auto_cts_en,
   input  logic cts,
   input  logic store_empty,
   input  logic ser_busy,
   output logic launch
);

   logic paced;
   logic peer_ok;

   assign paced   = fifo_en && auto_cts_en;
   assign peer_ok = !paced || cts;
   assign launch  = !store_empty && !ser_busy && peer_ok;

endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned OVS        = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick16,
   input  logic              fifo_en,
   input  logic              auto_cts_en,
   input  logic              flush,
   input  logic              cts,
   output logic              txd,
   output logic              dma_tx_ready,
   output logic              hold_empty,
   output logic              shift_empty
);

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("uart_tx_cts: FIFO_DEPTH must be at least 2");
      end
      if (OVS < 2) begin : g_bad_ovs
         $error("uart_tx_cts: OVS must be at least 2");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("uart_tx_cts: DATA_W must be 5 to 9");
      end
   endgenerate

   logic [DATA_W-1:0] head_data;
   logic              store_empty;
   logic              launch;
   logic              ser_busy;

   uart_tx_store #(
      .DATA_W (DATA_W),
      .DEPTH  (FIFO_DEPTH)
   ) store_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .single_mode (!fifo_en),
      .push_req    (wr_en),
      .push_data   (wr_data),
      .pop         (launch),
      .head_data   (head_data),
      .is_empty    (store_empty),
      .can_accept  (dma_tx_ready)
   );

   uart_tx_launch launch_i (
      .fifo_en     (fifo_en),
      .auto_cts_en (auto_cts_en),
      .cts         (cts),
      .store_empty (store_empty),
      .ser_busy    (ser_busy),
      .launch      (launch)
   );

   uart_tx_serializer #(
      .DATA_W (DATA_W),
      .OVS    (OVS)
   ) ser_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick16),
      .start      (launch),
      .start_data (head_data),
      .busy       (ser_busy),
      .txd        (txd)
   );

   assign hold_empty  = store_empty;
   assign shift_empty = store_empty && !ser_busy;

endmodule

// File: rtl/uart_tx_cts_chk.sv
module uart_tx_cts_chk (
   input logic clk,
   input logic rst_n,
   input logic fifo_en,
   input logic auto_cts_en,
   input logic cts,
   input logic flush,
   input logic txd,
   input logic dma_tx_ready,
   input logic hold_empty,
   input logic shift_empty,
   input logic ser_busy
);

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) shift_empty |-> txd); // R1

   AST_SHIFT_IMPLIES_HOLD: assert property (@(posedge clk) disable iff (!rst_n) shift_empty |-> hold_empty); // R7

   AST_SINGLE_READY: assert property (@(posedge clk) disable iff (!rst_n) !fifo_en |-> (dma_tx_ready == hold_empty)); // R4

   AST_CTS_GATES_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(ser_busy) |-> $past(!(fifo_en && auto_cts_en) || cts)); // R9

   AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $fell(ser_busy) |-> $past(txd)); // R2

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) $past(flush) |-> hold_empty); // R12

endmodule

bind uart_tx_cts uart_tx_cts_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .fifo_en      (fifo_en),
   .auto_cts_en  (auto_cts_en),
   .cts          (cts),
   .flush        (flush),
   .txd          (txd),
   .dma_tx_ready (dma_tx_ready),
   .hold_empty   (hold_empty),
   .shift_empty  (shift_empty),
   .ser_busy     (ser_busy)
);

// File: tb/uart_tx_cts_tb_top.sv
`timescale 1ns/1ps
module uart_tx_cts_tb_top;

   localparam int DATA_W = 8;
   localparam int DEPTH  = 4;
   localparam int OVS    = 4;
   localparam int TDIV   = 2;
   localparam int BITCLK = OVS * TDIV;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              tick16 = 1'b0;
   logic              fifo_en = 1'b0;
   logic              auto_cts_en = 1'b0;
   logic              flush = 1'b0;
   logic              cts = 1'b1;
   logic              txd, dma_tx_ready, hold_empty, shift_empty;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   always #10 clk = ~clk;

   uart_tx_cts #(.DATA_W(DATA_W), .FIFO_DEPTH(DEPTH), .OVS(OVS)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick16(tick16),
      .fifo_en(fifo_en), .auto_cts_en(auto_cts_en), .flush(flush), .cts(cts),
      .txd(txd), .dma_tx_ready(dma_tx_ready), .hold_empty(hold_empty), .shift_empty(shift_empty)
   );

   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         ph++;
         tick16 = (ph % TDIV) == 0;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr_one(input logic [7:0] d);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rx_frame(input string req, input logic [7:0] exp);
      logic [7:0] b = '0;
      int w = 0;
      while (txd !== 1'b0 && w < 5000) begin
         @(negedge clk);
         w++;
      end
      repeat (BITCLK / 2) @(negedge clk);
      chk(req, "start bit level", int'(txd), 0);
      for (int i = 0; i < 8; i++) begin
         repeat (BITCLK) @(negedge clk);
         b[i] = txd;
      end
      repeat (BITCLK) @(negedge clk);
      chk(req, "stop bit level", int'(txd), 1);
      chk(req, "received byte", int'(b), int'(exp));
   endtask

   task automatic quiet(input string req, input int n);
      int lows = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) lows++;
      end
      chk(req, "low samples on idle line", lows, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "txd after reset", int'(txd), 1);
      chk("R1", "hold_empty after reset", int'(hold_empty), 1);
      chk("R1", "shift_empty after reset", int'(shift_empty), 1);
      chk("R1", "dma_tx_ready after reset", int'(dma_tx_ready), 1);
   endtask

   task automatic t_single;
      fifo_en = 1'b0;
      fork
         begin
            rx_frame("R2", 8'hA5);
            rx_frame("R4", 8'h3C);
         end
         begin
            wr_one(8'hA5);
            chk("R4", "ready with slot held", int'(dma_tx_ready), 0);
            chk("R7", "hold_empty with slot held", int'(hold_empty), 0);
            @(negedge clk);
            chk("R4", "ready after launch", int'(dma_tx_ready), 1);
            chk("R7", "hold_empty after launch", int'(hold_empty), 1);
            chk("R7", "shift_empty while sending", int'(shift_empty), 0);
            wr_one(8'h3C);
            chk("R4", "ready with second byte held", int'(dma_tx_ready), 0);
            wr_one(8'h77);
         end
      join
      quiet("R4", 3 * BITCLK);
      chk("R7", "shift_empty after drain", int'(shift_empty), 1);
   endtask

   task automatic t_bit_time;
      int hi = 0;
      fifo_en = 1'b0;
      wr_one(8'h0F);
      while (txd !== 1'b0) @(negedge clk);
      while (txd !== 1'b1) @(negedge clk);
      while (txd === 1'b1) begin
         hi++;
         @(negedge clk);
      end
      chk("R3", "clocks in four high data bits", hi, 4 * BITCLK);
      while (shift_empty !== 1'b1) @(negedge clk);
   endtask

   task automatic t_fifo_full;
      fifo_en = 1'b1;
      auto_cts_en = 1'b0;
      fork
         begin
            rx_frame("R5", 8'h10);
            rx_frame("R5", 8'h21);
            rx_frame("R8", 8'h32);
            rx_frame("R6", 8'h43);
            rx_frame("R6", 8'h54);
         end
         begin
            wr_one(8'h10);
            wr_one(8'h21);
            wr_one(8'h32);
            wr_one(8'h43);
            wr_one(8'h54);
            chk("R5", "ready when queue full", int'(dma_tx_ready), 0);
            wr_one(8'h66);
            chk("R6", "ready after write to full queue", int'(dma_tx_ready), 0);
         end
      join
      quiet("R6", 3 * BITCLK);
   endtask

   task automatic t_flush;
      fifo_en = 1'b1;
      auto_cts_en = 1'b0;
      fork
         rx_frame("R12", 8'h81);
         begin
            wr_one(8'h81);
            wr_one(8'h82);
            wr_one(8'h83);
            flush = 1'b1;
            wr_one(8'h99);
            flush = 1'b0;
            chk("R12", "hold_empty after flush", int'(hold_empty), 1);
            chk("R12", "shift_empty while frame runs", int'(shift_empty), 0);
         end
      join
      quiet("R12", 3 * BITCLK);
      chk("R12", "shift_empty after flushed run", int'(shift_empty), 1);
   endtask

   task automatic t_cts;
      fifo_en = 1'b1;
      auto_cts_en = 1'b1;
      cts = 1'b0;
      wr_one(8'h11);
      quiet("R9", 100);
      chk("R9", "hold_empty while paused", int'(hold_empty), 0);
      chk("R9", "shift_empty while paused", int'(shift_empty), 0);
      fork
         rx_frame("R9", 8'h11);
         cts = 1'b1;
      join
      while (shift_empty !== 1'b1) @(negedge clk);
      fork
         rx_frame("R10", 8'h22);
         begin
            wr_one(8'h22);
            wr_one(8'h33);
            repeat (20) @(negedge clk);
            cts = 1'b0;
         end
      join
      quiet("R9", 60);
      chk("R9", "byte waits while cts low", int'(hold_empty), 0);
      fork
         rx_frame("R9", 8'h33);
         cts = 1'b1;
      join
      while (shift_empty !== 1'b1) @(negedge clk);
   endtask

   task automatic t_cts_single;
      fifo_en = 1'b0;
      auto_cts_en = 1'b1;
      cts = 1'b0;
      fork
         rx_frame("R11", 8'h5A);
         wr_one(8'h5A);
      join
      while (shift_empty !== 1'b1) @(negedge clk);
      chk("R11", "shift_empty after unpaced frame", int'(shift_empty), 1);
      cts = 1'b1;
      auto_cts_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      t_single();
      t_bit_time();
      t_fifo_full();
      t_flush();
      t_cts();
      t_cts_single();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule